// File: doc/BRIEF.md
# Random Generator Interrupt and Health Status Controller

This block holds the interrupt and health status for a random-number generator attached to a simple word-addressed register bus. Four event sources come in as one-cycle pulses from neighbouring logic: a debiaser error (a long run of identical raw bits), a repeated-block error (two equal consecutive sample blocks), a data-ready indication, and the result of each autocorrelation test run. The block latches each event into a status bit. Each source has a mask bit and a write-one-to-clear bit, and the block drives a single registered interrupt line.

The autocorrelation source is handled differently from the other three. Its status bit is set only after a run of consecutive failing tests. Once set, it stays set whatever software writes to the clear register, and it drives a halt line that stops the generator. Only the hardware reset or the software-reset register clears it. The block also keeps a pair of statistics counters, one for test attempts and one for test failures. Both sit in one register, both are wiped by any write to that register, and both freeze together as soon as either one reaches its maximum value.

Top module: `rng_irq_status_ctrl`

## Requirements
- R1: After reset the mask register reads 0xF, and the status register, both statistics counters, `irq_o`, `halt_o` and `soft_rst_o` are all zero. Word addresses are: 0 mask, 1 status (read-only), 2 clear (write-only, reads 0), 3 statistics, 4 software reset (write-only, reads 0).
- R2: A pulse on `ev_debias_i`, `ev_repeat_i` or `ev_ready_i` sets status bit 3, 2 or 0 respectively, and the bit can be read on the next cycle. Status bits 31:4 always read as zero.
- R3: Writing the clear register clears status bits 3, 2 and 0 wherever the written data holds a 1. Bits written as 0 keep their value.
- R4: When an event and a clear write hit the same status bit in the same cycle, the bit ends up set.
- R5: Status bit 1 (autocorrelation error) is set on the fourth consecutive failing test result (`ac_done_i` with `ac_fail_i`). A passing result (`ac_done_i` with `ac_fail_i` low) restarts the run from zero.
- R6: Status bit 1 ignores writes to the clear register. `halt_o` is high exactly while status bit 1 is set.
- R7: `irq_o` is the OR over the four bits of status AND NOT mask, registered, so it follows the status and mask registers one cycle later. A mask bit of 1 suppresses its source.
- R8: The statistics register holds the attempts count in bits 13:0, incremented on each `ac_start_i` pulse, and the failures count in bits 21:14, incremented on each failing result. Bits 31:22 read as zero.
- R9: Any write to the statistics register, whatever the data, zeroes both counters.
- R10: While the attempts count equals 16383 or the failures count equals 255, neither counter changes until a statistics write.
- R11: Writing 1 in bit 0 of the software-reset register clears every status bit (bit 1 included), the failure run and both counters, leaves the mask untouched, and drives `soft_rst_o` high for one cycle. A write with bit 0 at 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 3 | Word address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| ev_debias_i | input | 1 | Debiaser error pulse |
| ev_repeat_i | input | 1 | Repeated-block error pulse |
| ev_ready_i | input | 1 | Data-ready pulse |
| ac_start_i | input | 1 | Autocorrelation test started |
| ac_done_i | input | 1 | Autocorrelation test result valid |
| ac_fail_i | input | 1 | Result is a failure (qualified by `ac_done_i`) |
| irq_o | output | 1 | Combined registered interrupt |
| halt_o | output | 1 | Generator halt while the autocorrelation error is set |
| soft_rst_o | output | 1 | One-cycle pulse after a software reset write |

## Verification
The bench goes after the same-cycle collisions. An event together with a clear write must leave the bit set; a design that gives the clear priority would lose a data-ready indication. A clear write with all bits set must leave the autocorrelation bit alone; a design that treats all four bits alike would lift the halt from software. The failure-run tests insert a passing result after three failures, which catches a counter that tallies failures in total rather than in a row. The saturation tests drive each counter to its maximum separately and check that the other counter also stops, which catches a design that freezes only the counter that saturated or lets it wrap to zero.

// File: rtl/rng_irq_pkg.sv
package rng_irq_pkg;
  localparam int REG_AW = 3;
  localparam int NFLAG  = 4;

  localparam logic [REG_AW-1:0] ADR_MASK   = 3'd0;
  localparam logic [REG_AW-1:0] ADR_STATUS = 3'd1;
  localparam logic [REG_AW-1:0] ADR_CLEAR  = 3'd2;
  localparam logic [REG_AW-1:0] ADR_STATS  = 3'd3;
  localparam logic [REG_AW-1:0] ADR_SWRST  = 3'd4;

  // status bit positions, decoded by software
  localparam int FB_READY  = 0;
  localparam int FB_ACORR  = 1;
  localparam int FB_REPEAT = 2;
  localparam int FB_DEBIAS = 3;

  // only the autocorrelation flag is immune to software clear
  localparam logic [NFLAG-1:0] STICKY_FLAGS = 4'b0010;
  localparam logic [NFLAG-1:0] MASK_RST     = 4'hF;

  typedef struct packed {
    logic mask_we;
    logic clear_we;
    logic stats_we;
    logic swrst;
  } wr_strobe_t;
endpackage

// File: rtl/rng_flag_bank.sv
module rng_flag_bank
  import rng_irq_pkg::*;
#(
  parameter int               N      = NFLAG,
  parameter logic [N-1:0]     STICKY = STICKY_FLAGS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_clr,
  input  logic [N-1:0] set_i,
  input  logic         clr_we,
  input  logic [N-1:0] clr_bits,
  output logic [N-1:0] flag_q
);
  logic [N-1:0] flag_d;

  for (genvar i = 0; i < N; i++) begin : g_flag
    if (STICKY[i]) begin : g_sticky
      always_comb begin
        if (soft_clr) flag_d[i] = 1'b0;
        else          flag_d[i] = flag_q[i] | set_i[i];
      end
    end else begin : g_clearable
      always_comb begin
        if (soft_clr)
          flag_d[i] = 1'b0;
        else if (set_i[i])
          flag_d[i] = 1'b1;
        else if (clr_we && clr_bits[i])
          flag_d[i] = 1'b0;
        else
          flag_d[i] = flag_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end
endmodule

// File: rtl/rng_ac_streak.sv
module rng_ac_streak #(
  parameter int RUN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_clr,
  input  logic done_i,
  input  logic fail_i,
  output logic trip_o
);
  localparam int CW = (RUN > 2) ? $clog2(RUN) : 1;
  localparam logic [CW-1:0] TOP = CW'(RUN - 1);

  logic [CW-1:0] run_q, run_d;
  logic          run_en;

  assign trip_o = done_i && fail_i && (run_q == TOP);
  assign run_en = soft_clr || done_i;

  always_comb begin
    if (soft_clr)
      run_d = '0;
    else if (!fail_i)
      run_d = '0;
    else if (run_q == TOP)
      run_d = run_q;
    else
      run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (run_en) run_q <= run_d;
  end
endmodule

// File: rtl/rng_ac_stats.sv
module rng_ac_stats #(
  parameter int ATT_W  = 14,
  parameter int FAIL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              wipe_i,
  input  logic              start_i,
  input  logic              fail_i,
  output logic [ATT_W-1:0]  att_q,
  output logic [FAIL_W-1:0] fail_q
);
  logic              frozen;
  logic [ATT_W-1:0]  att_d;
  logic [FAIL_W-1:0] fail_d;
  logic              att_en, fail_en;

  assign frozen = (&att_q) || (&fail_q);

  always_comb begin
    att_en  = 1'b0;
    fail_en = 1'b0;
    att_d   = att_q;
    fail_d  = fail_q;
    if (soft_clr || wipe_i) begin
      att_en  = 1'b1;
      fail_en = 1'b1;
      att_d   = '0;
      fail_d  = '0;
    end else if (!frozen) begin
      att_en  = start_i;
      fail_en = fail_i;
      att_d   = att_q + 1'b1;
      fail_d  = fail_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       att_q <= '0;
    else if (att_en)  att_q <= att_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fail_q <= '0;
    else if (fail_en) fail_q <= fail_d;
  end
endmodule

// File: rtl/rng_reg_if.sv
module rng_reg_if
  import rng_irq_pkg::*;
#(
  parameter int DW     = 32,
  parameter int ATT_W  = 14,
  parameter int FAIL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NFLAG-1:0]  status_i,
  input  logic [ATT_W-1:0]  att_i,
  input  logic [FAIL_W-1:0] fail_i,
  output wr_strobe_t        stb_o,
  output logic [NFLAG-1:0]  mask_q
);
  localparam int STAT_PAD = DW - ATT_W - FAIL_W;
  localparam int FLAG_PAD = DW - NFLAG;

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata[DW-1:NFLAG];

  always_comb begin
    stb_o.mask_we  = bus_we && (bus_addr == ADR_MASK);
    stb_o.clear_we = bus_we && (bus_addr == ADR_CLEAR);
    stb_o.stats_we = bus_we && (bus_addr == ADR_STATS);
    stb_o.swrst    = bus_we && (bus_addr == ADR_SWRST) && bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             mask_q <= MASK_RST;
    else if (stb_o.mask_we) mask_q <= bus_wdata[NFLAG-1:0];
  end

  always_comb begin
    case (bus_addr)
      ADR_MASK:   bus_rdata = {{FLAG_PAD{1'b0}}, mask_q};
      ADR_STATUS: bus_rdata = {{FLAG_PAD{1'b0}}, status_i};
      ADR_STATS:  bus_rdata = {{STAT_PAD{1'b0}}, fail_i, att_i};
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rng_irq_status_ctrl.sv
module rng_irq_status_ctrl
  import rng_irq_pkg::*;
#(
  parameter int DW     = 32,
  parameter int ATT_W  = 14,
  parameter int FAIL_W = 8,
  parameter int AC_RUN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              ev_debias_i,
  input  logic              ev_repeat_i,
  input  logic              ev_ready_i,
  input  logic              ac_start_i,
  input  logic              ac_done_i,
  input  logic              ac_fail_i,
  output logic              irq_o,
  output logic              halt_o,
  output logic              soft_rst_o
);
  wr_strobe_t        stb;
  logic [NFLAG-1:0]  mask_q;
  logic [NFLAG-1:0]  status_q;
  logic [NFLAG-1:0]  set_vec;
  logic [ATT_W-1:0]  att_q;
  logic [FAIL_W-1:0] fail_q;
  logic              ac_trip;
  logic              ac_bad;
  logic              irq_d;

  assign ac_bad = ac_done_i && ac_fail_i;

  rng_reg_if #(.DW(DW), .ATT_W(ATT_W), .FAIL_W(FAIL_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .status_i  (status_q),
    .att_i     (att_q),
    .fail_i    (fail_q),
    .stb_o     (stb),
    .mask_q    (mask_q)
  );

  rng_ac_streak #(.RUN(AC_RUN)) u_streak (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_clr (stb.swrst),
    .done_i   (ac_done_i),
    .fail_i   (ac_fail_i),
    .trip_o   (ac_trip)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[FB_DEBIAS] = ev_debias_i;
    set_vec[FB_REPEAT] = ev_repeat_i;
    set_vec[FB_READY]  = ev_ready_i;
    set_vec[FB_ACORR]  = ac_trip;
  end

  rng_flag_bank #(.N(NFLAG), .STICKY(STICKY_FLAGS)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_clr (stb.swrst),
    .set_i    (set_vec),
    .clr_we   (stb.clear_we),
    .clr_bits (bus_wdata[NFLAG-1:0]),
    .flag_q   (status_q)
  );

  rng_ac_stats #(.ATT_W(ATT_W), .FAIL_W(FAIL_W)) u_stats (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_clr (stb.swrst),
    .wipe_i   (stb.stats_we),
    .start_i  (ac_start_i),
    .fail_i   (ac_bad),
    .att_q    (att_q),
    .fail_q   (fail_q)
  );

  assign irq_d  = |(status_q & ~mask_q);
  assign halt_o = status_q[FB_ACORR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o      <= 1'b0;
      soft_rst_o <= 1'b0;
    end else begin
      irq_o      <= irq_d;
      soft_rst_o <= stb.swrst;
    end
  end
endmodule

// File: rtl/rng_irq_status_chk.sv
module rng_irq_status_chk
  import rng_irq_pkg::*;
#(
  parameter int ATT_W  = 14,
  parameter int FAIL_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [REG_AW-1:0] bus_addr,
  input logic              wd0,
  input logic              ev_ready_i,
  input logic              ac_done_i,
  input logic              ac_fail_i,
  input logic              irq_o,
  input logic              halt_o,
  input logic              soft_rst_o,
  input logic [NFLAG-1:0]  status_q,
  input logic [NFLAG-1:0]  mask_q,
  input logic [ATT_W-1:0]  att_q,
  input logic [FAIL_W-1:0] fail_q
);
  logic swrst_wr, stats_wr;
  assign swrst_wr = bus_we && (bus_addr == ADR_SWRST) && wd0;
  assign stats_wr = bus_we && (bus_addr == ADR_STATS);

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ready_i && !swrst_wr) |=> status_q[FB_READY]);

  // R5
  ac_needs_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_o) |-> $past(ac_done_i && ac_fail_i));

  // R6
  ac_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_o && !swrst_wr) |=> halt_o);

  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 4'hF) |=> !irq_o);

  // R10
  stats_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&att_q || &fail_q) && !stats_wr && !swrst_wr) |=> ($stable(att_q) && $stable(fail_q)));

  // R11
  soft_rst_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |-> (status_q == '0 && att_q == '0 && fail_q == '0));
endmodule

bind rng_irq_status_ctrl rng_irq_status_chk #(.ATT_W(ATT_W), .FAIL_W(FAIL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .wd0        (bus_wdata[0]),
  .ev_ready_i (ev_ready_i),
  .ac_done_i  (ac_done_i),
  .ac_fail_i  (ac_fail_i),
  .irq_o      (irq_o),
  .halt_o     (halt_o),
  .soft_rst_o (soft_rst_o),
  .status_q   (status_q),
  .mask_q     (mask_q),
  .att_q      (att_q),
  .fail_q     (fail_q)
);

// File: tb/tb_rng_irq_status_ctrl.sv
module tb_rng_irq_status_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic ev_debias_i, ev_repeat_i, ev_ready_i;
  logic ac_start_i, ac_done_i, ac_fail_i;
  logic irq_o, halt_o, soft_rst_o;

  always #10 clk = ~clk;

  rng_irq_status_ctrl dut (.*);

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_mask, m_st, m_run, m_att, m_fail;
  bit m_irq, m_srst;

  function automatic int m_read(int a);
    case (a)
      0: return m_mask;
      1: return m_st;
      3: return (m_fail << 14) | m_att;
      default: return 0;
    endcase
  endfunction

  task automatic m_reset();
    m_mask = 15; m_st = 0; m_run = 0; m_att = 0; m_fail = 0;
    m_irq = 0; m_srst = 0;
  endtask

  task automatic m_update();
    int st, run, att, fl, msk;
    bit sr;
    m_irq = ((m_st & ~m_mask & 15) != 0);
    sr = bus_we && bus_addr == 4 && bus_wdata[0];
    st = m_st; run = m_run; att = m_att; fl = m_fail; msk = m_mask;
    if (bus_we && bus_addr == 0) msk = bus_wdata & 15;
    if (sr) begin
      st = 0; run = 0; att = 0; fl = 0;
    end else begin
      if (bus_we && bus_addr == 2) st = st & ~(bus_wdata & 'hD);
      if (ev_debias_i) st = st | 8;
      if (ev_repeat_i) st = st | 4;
      if (ev_ready_i)  st = st | 1;
      if (ac_done_i) begin
        if (ac_fail_i) begin
          if (m_run == 3) st = st | 2;
          run = (m_run + 1 > 3) ? 3 : m_run + 1;
        end else run = 0;
      end
      if (bus_we && bus_addr == 3) begin
        att = 0; fl = 0;
      end else if (!(m_att == 16383 || m_fail == 255)) begin
        att = att + int'(ac_start_i);
        fl  = fl + int'(ac_done_i && ac_fail_i);
      end
    end
    m_st = st; m_run = run; m_att = att; m_fail = fl; m_mask = msk; m_srst = sr;
  endtask

  task automatic cmp(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    m_update();
    #5;
    cmp("rdata", int'(bus_rdata), m_read(int'(bus_addr)));
    cmp("irq", int'(irq_o), int'(m_irq));
    cmp("halt", int'(halt_o), (m_st >> 1) & 1);
    cmp("soft_rst", int'(soft_rst_o), int'(m_srst));
    @(negedge clk);
    bus_we = 0; bus_wdata = 0;
    ev_debias_i = 0; ev_repeat_i = 0; ev_ready_i = 0;
    ac_start_i = 0; ac_done_i = 0; ac_fail_i = 0;
  endtask

  task automatic wr(int a, int d);
    bus_we = 1; bus_addr = 3'(a); bus_wdata = d;
    cyc();
  endtask

  task automatic rd_chk(int a, int exp, string what);
    bus_addr = 3'(a);
    cyc();
    cmp(what, int'(bus_rdata), exp);
  endtask

  task automatic ac_result(bit fail);
    ac_start_i = 1; ac_done_i = 1; ac_fail_i = fail;
    cyc();
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    ev_debias_i = 0; ev_repeat_i = 0; ev_ready_i = 0;
    ac_start_i = 0; ac_done_i = 0; ac_fail_i = 0;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset values
    cur_req = "R1";
    rd_chk(0, 'hF, "mask reset");
    rd_chk(1, 0, "status reset");
    rd_chk(3, 0, "stats reset");
    cmp("irq reset", int'(irq_o), 0);

    // R2 event latching
    cur_req = "R2";
    bus_addr = 1; ev_debias_i = 1; cyc();
    cmp("debias bit3", int'(bus_rdata), 8);
    ev_repeat_i = 1; cyc();
    ev_ready_i = 1; cyc();
    cmp("all events", int'(bus_rdata), 'hD);

    // R7 interrupt masking
    cur_req = "R7";
    cmp("irq masked", int'(irq_o), 0);
    wr(0, 'hE);
    cyc();
    cmp("irq ready unmasked", int'(irq_o), 1);
    wr(0, 'hF);
    cyc();
    cmp("irq remasked", int'(irq_o), 0);

    // R3 write-one-to-clear
    cur_req = "R3";
    wr(2, 'h8);
    rd_chk(1, 'h5, "clear bit3 only");
    wr(2, 'hFFFF_FFFF);
    rd_chk(1, 0, "clear all");

    // R4 set beats clear
    cur_req = "R4";
    ev_ready_i = 1; bus_we = 1; bus_addr = 2; bus_wdata = 1; cyc();
    bus_addr = 1; cyc();
    cmp("set wins", int'(bus_rdata), 1);
    wr(2, 1);

    // R5 consecutive failure run
    cur_req = "R5";
    wr(3, 0);
    for (int i = 0; i < 3; i++) ac_result(1);
    ac_result(0);
    for (int i = 0; i < 3; i++) ac_result(1);
    bus_addr = 1; cyc();
    cmp("no trip after broken run", int'(halt_o), 0);
    ac_result(1);
    cmp("trip on fourth", int'(halt_o), 1);
    rd_chk(1, 2, "acorr bit1");

    // R6 sticky against clear
    cur_req = "R6";
    wr(2, 'hF);
    rd_chk(1, 2, "acorr survives clear");
    cmp("halt held", int'(halt_o), 1);

    // R8 counter packing
    cur_req = "R8";
    wr(3, 'h1234);
    ac_start_i = 1; cyc();
    ac_start_i = 1; cyc();
    ac_done_i = 1; ac_fail_i = 1; cyc();
    ac_done_i = 1; ac_fail_i = 0; cyc();
    rd_chk(3, (1 << 14) | 2, "packed stats");

    // R9 any write wipes
    cur_req = "R9";
    wr(3, 'hDEAD_BEEF);
    rd_chk(3, 0, "stats wiped");

    // R10 saturation freeze, failures first
    cur_req = "R10";
    for (int i = 0; i < 255; i++) begin
      ac_done_i = 1; ac_fail_i = 1; cyc();
    end
    ac_start_i = 1; ac_done_i = 1; ac_fail_i = 1; cyc();
    rd_chk(3, (255 << 14) | 0, "fail saturated, attempts frozen");
    wr(3, 0);
    for (int i = 0; i < 16383; i++) begin
      ac_start_i = 1; cyc();
    end
    ac_done_i = 1; ac_fail_i = 1; ac_start_i = 1; cyc();
    rd_chk(3, 16383, "attempts saturated, fails frozen");

    // R11 software reset
    cur_req = "R11";
    ev_debias_i = 1; cyc();
    wr(4, 'hFFFF_FFFE);
    rd_chk(1, 'hA, "swrst bit0 clear no effect");
    wr(0, 'h6);
    wr(4, 1);
    cmp("soft_rst pulse", int'(soft_rst_o), 1);
    rd_chk(1, 0, "status after swrst");
    cmp("halt released", int'(halt_o), 0);
    rd_chk(3, 0, "stats after swrst");
    rd_chk(0, 6, "mask kept");
    for (int i = 0; i < 3; i++) ac_result(1);
    cmp("run restarted", int'(halt_o), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule